// File: doc/BRIEF.md
# Per-Circuit Segment CRC and Length Accumulator

This block follows the reassembly of many virtual circuits at once. Each received cell arrives as a segment of 48 payload bytes, streamed as six beats of eight bytes. The first beat also carries the circuit number, a first-cell flag, a timestamp and a buffer start address. The block loads that circuit's saved state from an internal context table. The state holds a running CRC-32, a byte count, a free-buffer address and a timestamp. The block folds the segment into the CRC at eight bytes per clock, adds 48 to the count and moves the buffer address on by one segment. It then presents the result on a write-back port and stores it back into the table.

A first cell starts a new packet. The CRC restarts from all ones, the count restarts from zero, the buffer address is taken from the supplied start address, and the supplied timestamp is captured. When the circuit's timer option is set, a first cell also raises a one-cycle request to add the circuit to a timer list. Cells of different circuits may interleave freely at cell boundaries. A cell that follows directly behind another cell of the same circuit picks up the result of that cell even though the result has not yet reached the table.

Top module: `vc_crc_accum`

## Requirements
- R1: A cell is exactly six accepted beats (beat_valid high). The first of them has beat_sof high and the other five have it low. The result appears on the wb_* outputs with wb_valid high for exactly one cycle: the cycle after the clock edge that accepts the sixth beat. At all other times wb_valid is low.
- R2: The CRC uses the generator 0x04C11DB7. Bits are taken most significant first, and bytes go in stream order, with beat_data[63:56] being the first byte of a beat. There is no bit reflection and no final inversion. wb_crc is the running value after the segment.
- R3: On a first cell (cell_first high on the sof beat), the CRC starts from 0xFFFFFFFF and the count starts from 0, whatever the circuit held before. As a result wb_len is 48.
- R4: On a continuing cell, the circuit's saved CRC and count are restored. wb_crc continues from the saved CRC, and wb_len equals the saved count plus 48.
- R5: wb_addr is the next free-buffer address, advanced by 48. On a first cell it is cell_buf_addr + 48. On a continuing cell it is the saved address + 48.
- R6: wb_ts is cell_ts captured on a first cell. On continuing cells it is the saved timestamp, unchanged.
- R7: timer_req is high alongside wb_valid only when the cell was a first cell and vc_timer_en[circuit] is 1. Otherwise it is low.
- R8: A cell whose sof beat is accepted in the cycle where wb_valid is high for the same circuit uses that write-back result as its saved state. A different circuit in that cycle is not affected by it.
- R9: A cell updates only its own circuit's context. Cells on other circuits leave it unchanged.
- R10: After reset, wb_valid and timer_req are low. Every circuit holds CRC 0xFFFFFFFF, count 0, address 0 and timestamp 0, so a continuing cell on an untouched circuit yields wb_len 48, wb_addr 48 and wb_ts 0.
- R11: Idle cycles (beat_valid low) between beats of a cell do not change the result. cell_vc, cell_first, cell_ts and cell_buf_addr are ignored on beats other than the sof beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| beat_valid | input | 1 | A payload beat is present this cycle |
| beat_sof | input | 1 | This beat is the first of a cell |
| beat_data | input | 64 | Eight payload bytes, first byte in [63:56] |
| cell_vc | input | 4 | Circuit number, read on the sof beat |
| cell_first | input | 1 | Cell starts a packet, read on the sof beat |
| cell_ts | input | 16 | Timestamp to capture on a first cell |
| cell_buf_addr | input | 32 | Buffer start address for a first cell |
| vc_timer_en | input | 16 | Timer option, one bit per circuit |
| wb_valid | output | 1 | Write-back result valid (one cycle per cell) |
| wb_vc | output | 4 | Circuit of the result |
| wb_first | output | 1 | Result belongs to a first cell |
| wb_crc | output | 32 | Running CRC after the segment |
| wb_len | output | 16 | Byte count after the segment |
| wb_addr | output | 32 | Next free-buffer address |
| wb_ts | output | 16 | Packet timestamp |
| timer_req | output | 1 | Request to add the circuit to the timer list |

## Verification
On every cycle the assertions check the beat framing, the single-cycle write-back pulse, the gating of timer_req, and the 48-byte count of a first cell. They also check that a forwarded restore takes the pending result and that a stored result reads back on the following cycle. The CRC value itself, address and timestamp carry-over, isolation between circuits, the ignored sideband on later beats, and the reset contents of untouched circuits can be shown only by the bench's directed cells. The bench compares those results against its own bit-serial CRC and its own context model.

// File: rtl/vca_pkg.sv
// Package: shared constants and the byte-wide CRC-32 update used by the
// accumulator. Assumes the non-reflected, MSB-first form of the CRC.
package vca_pkg;
    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    // Folds one byte into a running CRC, most significant bit first.
    function automatic logic [31:0] crc32_byte(input logic [31:0] crc_in,
                                               input logic [7:0]  byte_in);
        logic [31:0] r;
        r = crc_in;
        for (int i = 7; i >= 0; i--) begin
            if (r[31] ^ byte_in[i])
                r = (r << 1) ^ CRC_POLY;
            else
                r = r << 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/vca_crc_step.sv
// Combinational CRC-32 update over BYTES bytes in one clock.
// Assumes the first byte in stream order sits in the top byte of data.
module vca_crc_step
    import vca_pkg::*;
#(
    parameter int BYTES = 8,
    localparam int DATA_W = 8 * BYTES
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] chain [0:BYTES];

    assign chain[0] = crc_in;

    // One byte stage per lane, chained from the top byte down.
    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        assign chain[g+1] = crc32_byte(chain[g], data[DATA_W-1-8*g -: 8]);
    end

    assign crc_out = chain[BYTES];
endmodule

// File: rtl/vca_beat_ctrl.sv
// Beat sequencer: counts the beats of a segment and marks the sof and the
// last beat. Assumes every cell is exactly BEATS accepted beats (BEATS >= 2).
module vca_beat_ctrl #(
    parameter int BEATS = 6,
    localparam int IDX_W = $clog2(BEATS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_valid,
    input  logic beat_sof,
    output logic sof_beat,
    output logic last_beat
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

    logic [IDX_W-1:0] idx;

    // Position of the next expected beat within the segment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (beat_valid) begin
            if (beat_sof)
                idx <= IDX_W'(1);
            else if (idx == LAST_IDX)
                idx <= '0;
            else
                idx <= idx + IDX_W'(1);
        end
    end

    // Beat classification for the datapath.
    always_comb begin
        sof_beat  = beat_valid && beat_sof;
        last_beat = beat_valid && !beat_sof && (idx == LAST_IDX);
    end

    // Input framing: a sof beat comes only at a segment boundary.
    p_sof_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_sof) |-> (idx == '0));

    // Input framing: no body beat is offered at a segment boundary.
    p_no_stray_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_sof) |-> (idx != '0));
endmodule

// File: rtl/vca_ctx_mem.sv
// Per-circuit context table: CRC, count, buffer address and timestamp.
// Asynchronous read, one synchronous write port; reset fills the table
// with the start-of-packet defaults.
module vca_ctx_mem
    import vca_pkg::*;
#(
    parameter int NUM_VC = 16,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 32,
    parameter int TS_W   = 16,
    localparam int VC_W  = $clog2(NUM_VC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VC_W-1:0]   rd_vc,
    output logic [CRC_W-1:0]  rd_crc,
    output logic [LEN_W-1:0]  rd_len,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [TS_W-1:0]   rd_ts,
    input  logic              wr_en,
    input  logic [VC_W-1:0]   wr_vc,
    input  logic [CRC_W-1:0]  wr_crc,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TS_W-1:0]   wr_ts
);
    logic [CRC_W-1:0]  crc_q  [NUM_VC];
    logic [LEN_W-1:0]  len_q  [NUM_VC];
    logic [ADDR_W-1:0] addr_q [NUM_VC];
    logic [TS_W-1:0]   ts_q   [NUM_VC];

    // Table update: reset to defaults, otherwise store the write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_VC; i++) begin
                crc_q[i]  <= CRC_INIT;
                len_q[i]  <= '0;
                addr_q[i] <= '0;
                ts_q[i]   <= '0;
            end
        end else if (wr_en) begin
            crc_q[wr_vc]  <= wr_crc;
            len_q[wr_vc]  <= wr_len;
            addr_q[wr_vc] <= wr_addr;
            ts_q[wr_vc]   <= wr_ts;
        end
    end

    // Restore path for the circuit addressed by the current sof beat.
    always_comb begin
        rd_crc  = crc_q[rd_vc];
        rd_len  = len_q[rd_vc];
        rd_addr = addr_q[rd_vc];
        rd_ts   = ts_q[rd_vc];
    end

    // A written result is the stored context on the next cycle.
    p_wr_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (crc_q[$past(wr_vc)] == $past(wr_crc)) &&
                  (len_q[$past(wr_vc)] == $past(wr_len)));
endmodule

// File: rtl/vc_crc_accum.sv
// Per-circuit CRC-32 and length accumulator. Restores a circuit's context
// on the sof beat, folds eight bytes per clock into the CRC, and issues a
// one-cycle write-back that is also stored into the context table.
// Assumes well-framed cells of SEG_BYTES/BEAT_BYTES beats, at least two.
module vc_crc_accum
    import vca_pkg::*;
#(
    parameter int NUM_VC     = 16,
    parameter int BEAT_BYTES = 8,
    parameter int SEG_BYTES  = 48,
    parameter int LEN_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int TS_W       = 16,
    localparam int VC_W      = $clog2(NUM_VC),
    localparam int DATA_W    = 8 * BEAT_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid,
    input  logic              beat_sof,
    input  logic [DATA_W-1:0] beat_data,
    input  logic [VC_W-1:0]   cell_vc,
    input  logic              cell_first,
    input  logic [TS_W-1:0]   cell_ts,
    input  logic [ADDR_W-1:0] cell_buf_addr,
    input  logic [NUM_VC-1:0] vc_timer_en,
    output logic              wb_valid,
    output logic [VC_W-1:0]   wb_vc,
    output logic              wb_first,
    output logic [CRC_W-1:0]  wb_crc,
    output logic [LEN_W-1:0]  wb_len,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [TS_W-1:0]   wb_ts,
    output logic              timer_req
);
    localparam int BEATS = SEG_BYTES / BEAT_BYTES;
    localparam logic [LEN_W-1:0]  SEG_LEN  = LEN_W'(SEG_BYTES);
    localparam logic [ADDR_W-1:0] SEG_STEP = ADDR_W'(SEG_BYTES);

    logic sof_beat, last_beat;

    logic [CRC_W-1:0]  rd_crc;
    logic [LEN_W-1:0]  rd_len;
    logic [ADDR_W-1:0] rd_addr;
    logic [TS_W-1:0]   rd_ts;

    logic              fwd_hit;
    logic [CRC_W-1:0]  src_crc;
    logic [LEN_W-1:0]  src_len;
    logic [ADDR_W-1:0] src_addr;
    logic [TS_W-1:0]   src_ts;

    logic [CRC_W-1:0]  step_in, step_out;

    logic [VC_W-1:0]   w_vc;
    logic              w_first;
    logic [CRC_W-1:0]  w_crc;
    logic [LEN_W-1:0]  w_len;
    logic [ADDR_W-1:0] w_addr;
    logic [TS_W-1:0]   w_ts;

    vca_beat_ctrl #(
        .BEATS (BEATS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (beat_valid),
        .beat_sof   (beat_sof),
        .sof_beat   (sof_beat),
        .last_beat  (last_beat)
    );

    vca_ctx_mem #(
        .NUM_VC (NUM_VC),
        .LEN_W  (LEN_W),
        .ADDR_W (ADDR_W),
        .TS_W   (TS_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_vc   (cell_vc),
        .rd_crc  (rd_crc),
        .rd_len  (rd_len),
        .rd_addr (rd_addr),
        .rd_ts   (rd_ts),
        .wr_en   (wb_valid),
        .wr_vc   (wb_vc),
        .wr_crc  (wb_crc),
        .wr_len  (wb_len),
        .wr_addr (wb_addr),
        .wr_ts   (wb_ts)
    );

    // Source context: fresh packet, forwarded write-back, or stored table entry.
    always_comb begin
        fwd_hit = wb_valid && (wb_vc == cell_vc);
        if (cell_first) begin
            src_crc  = CRC_INIT;
            src_len  = '0;
            src_addr = cell_buf_addr;
            src_ts   = cell_ts;
        end else if (fwd_hit) begin
            src_crc  = wb_crc;
            src_len  = wb_len;
            src_addr = wb_addr;
            src_ts   = wb_ts;
        end else begin
            src_crc  = rd_crc;
            src_len  = rd_len;
            src_addr = rd_addr;
            src_ts   = rd_ts;
        end
        step_in = sof_beat ? src_crc : w_crc;
    end

    vca_crc_step #(
        .BYTES (BEAT_BYTES)
    ) u_step (
        .crc_in  (step_in),
        .data    (beat_data),
        .crc_out (step_out)
    );

    // Working context: captured on the sof beat, CRC advanced on each beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_vc    <= '0;
            w_first <= 1'b0;
            w_crc   <= CRC_INIT;
            w_len   <= '0;
            w_addr  <= '0;
            w_ts    <= '0;
        end else if (sof_beat) begin
            w_vc    <= cell_vc;
            w_first <= cell_first;
            w_crc   <= step_out;
            w_len   <= src_len;
            w_addr  <= src_addr;
            w_ts    <= src_ts;
        end else if (beat_valid) begin
            w_crc   <= step_out;
        end
    end

    // Write-back stage: one-cycle result after the last beat of a segment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid  <= 1'b0;
            wb_vc     <= '0;
            wb_first  <= 1'b0;
            wb_crc    <= CRC_INIT;
            wb_len    <= '0;
            wb_addr   <= '0;
            wb_ts     <= '0;
            timer_req <= 1'b0;
        end else begin
            wb_valid  <= last_beat;
            timer_req <= last_beat && w_first && vc_timer_en[w_vc];
            if (last_beat) begin
                wb_vc    <= w_vc;
                wb_first <= w_first;
                wb_crc   <= step_out;
                wb_len   <= w_len + SEG_LEN;
                wb_addr  <= w_addr + SEG_STEP;
                wb_ts    <= w_ts;
            end
        end
    end

    // The result follows the last beat by exactly one edge.
    p_wb_after_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> wb_valid);

    // No result appears without a completed segment.
    p_wb_only_after_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !last_beat |=> !wb_valid);

    // Timer request only for an enabled circuit's first cell.
    p_timer_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timer_req |-> (wb_valid && wb_first && vc_timer_en[wb_vc]));

    // A first cell's count is exactly one segment.
    p_first_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_first) |-> (wb_len == SEG_LEN));

    // A continuing cell behind a same-circuit result restores that result.
    p_fwd_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_beat && !cell_first && wb_valid && (wb_vc == cell_vc))
            |=> (w_len == $past(wb_len)) && (w_addr == $past(wb_addr)));
endmodule

// File: tb/tb_vc_crc_accum.sv
`timescale 1ns/1ps
module tb_vc_crc_accum;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        beat_valid, beat_sof;
    logic [63:0] beat_data;
    logic [3:0]  cell_vc;
    logic        cell_first;
    logic [15:0] cell_ts;
    logic [31:0] cell_buf_addr;
    logic [15:0] vc_timer_en;
    logic        wb_valid, wb_first, timer_req;
    logic [3:0]  wb_vc;
    logic [31:0] wb_crc, wb_addr;
    logic [15:0] wb_len, wb_ts;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Bench model of every circuit's context.
    logic [31:0] m_crc  [16];
    logic [15:0] m_len  [16];
    logic [31:0] m_addr [16];
    logic [15:0] m_ts   [16];

    always #4 clk = ~clk;

    vc_crc_accum dut (
        .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_sof(beat_sof),
        .beat_data(beat_data), .cell_vc(cell_vc), .cell_first(cell_first),
        .cell_ts(cell_ts), .cell_buf_addr(cell_buf_addr), .vc_timer_en(vc_timer_en),
        .wb_valid(wb_valid), .wb_vc(wb_vc), .wb_first(wb_first), .wb_crc(wb_crc),
        .wb_len(wb_len), .wb_addr(wb_addr), .wb_ts(wb_ts), .timer_req(timer_req)
    );

    // Bit-serial CRC over a whole 48-byte segment, first bit at [383].
    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [383:0] p);
        logic [31:0] r = c;
        for (int i = 383; i >= 0; i--) begin
            logic fb = r[31] ^ p[i];
            r = {r[30:0], 1'b0};
            if (fb) r = r ^ 32'h04C11DB7;
        end
        return r;
    endfunction

    function automatic logic [383:0] mk_payload(input logic [31:0] seed);
        logic [383:0] p;
        for (int k = 0; k < 12; k++)
            p[32*k +: 32] = (seed * 32'h9E3779B9) + (k * 32'h01000193) ^ (32'(k) << 20);
        return p;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drives one cell and checks its write-back against the model.
    task automatic send_cell(input int vc, input bit first, input logic [15:0] ts,
                             input logic [31:0] addr, input logic [383:0] pl,
                             input int gap, input string req);
        logic [31:0] e_crc, e_addr;
        logic [15:0] e_len, e_ts;
        bit e_tmr;
        if (first) begin
            e_crc = 32'hFFFF_FFFF; e_len = 16'd0; e_addr = addr; e_ts = ts;
        end else begin
            e_crc = m_crc[vc]; e_len = m_len[vc]; e_addr = m_addr[vc]; e_ts = m_ts[vc];
        end
        e_crc  = ref_crc(e_crc, pl);
        e_len  = e_len + 16'd48;
        e_addr = e_addr + 32'd48;
        e_tmr  = first && vc_timer_en[vc];
        m_crc[vc] = e_crc; m_len[vc] = e_len; m_addr[vc] = e_addr; m_ts[vc] = e_ts;
        for (int i = 0; i < 6; i++) begin
            if (i > 0 && gap > 0) begin
                @(negedge clk); beat_valid = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
            @(negedge clk);
            beat_valid = 1'b1;
            beat_sof   = (i == 0);
            beat_data  = pl[383 - 64*i -: 64];
            if (i == 0) begin
                cell_vc = 4'(vc); cell_first = first; cell_ts = ts; cell_buf_addr = addr;
            end else begin
                // Sideband garbage on body beats must be ignored (R11).
                cell_vc = 4'(vc) ^ 4'h1; cell_first = ~first;
                cell_ts = ~ts; cell_buf_addr = ~addr;
            end
        end
        @(posedge clk); #1;
        beat_valid = 1'b0;
        chk(wb_valid == 1'b1,  req, "wb_valid", 64'(wb_valid), 64'd1);
        chk(wb_vc == 4'(vc),   req, "wb_vc",    64'(wb_vc),    64'(vc));
        chk(wb_first == first, req, "wb_first", 64'(wb_first), 64'(first));
        chk(wb_crc == e_crc,   req, "wb_crc",   64'(wb_crc),   64'(e_crc));
        chk(wb_len == e_len,   req, "wb_len",   64'(wb_len),   64'(e_len));
        chk(wb_addr == e_addr, req, "wb_addr",  64'(wb_addr),  64'(e_addr));
        chk(wb_ts == e_ts,     req, "wb_ts",    64'(wb_ts),    64'(e_ts));
        chk(timer_req == e_tmr, req, "timer_req", 64'(timer_req), 64'(e_tmr));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; beat_valid = 1'b0; beat_sof = 1'b0; beat_data = '0;
        cell_vc = '0; cell_first = 1'b0; cell_ts = '0; cell_buf_addr = '0;
        vc_timer_en = 16'h00F0;
        for (int i = 0; i < 16; i++) begin
            m_crc[i] = 32'hFFFF_FFFF; m_len[i] = '0; m_addr[i] = '0; m_ts[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(wb_valid == 1'b0,  "R10", "wb_valid after reset", 64'(wb_valid), 64'd0);
        chk(timer_req == 1'b0, "R10", "timer_req after reset", 64'(timer_req), 64'd0);
    endtask

    // R1: the write-back pulse lasts one cycle only.
    task automatic t_single_pulse();
        @(posedge clk); #1;
        chk(wb_valid == 1'b0, "R1", "wb_valid second cycle", 64'(wb_valid), 64'd0);
    endtask

    task automatic t_first_and_continue();
        send_cell(5, 1'b1, 16'h1234, 32'h0000_1000, mk_payload(32'd1), 0, "R3");
        t_single_pulse();
        send_cell(5, 1'b0, 16'hAAAA, 32'hDEAD_0000, mk_payload(32'd2), 0, "R4");
        send_cell(5, 1'b0, 16'h5555, 32'h0,         mk_payload(32'd3), 0, "R2");
    endtask

    task automatic t_timer_and_isolation();
        send_cell(2, 1'b1, 16'h0777, 32'h0000_8000, mk_payload(32'd4), 0, "R7");
        send_cell(5, 1'b0, 16'h0,    32'h0,         mk_payload(32'd5), 0, "R9");
        send_cell(2, 1'b0, 16'h0,    32'h0,         mk_payload(32'd6), 0, "R6");
    endtask

    task automatic t_back_to_back();
        send_cell(9, 1'b1, 16'h0099, 32'h0002_0000, mk_payload(32'd7), 0, "R5");
        send_cell(9, 1'b0, 16'h0,    32'h0,         mk_payload(32'd8), 0, "R8");
        send_cell(9, 1'b0, 16'h0,    32'h0,         mk_payload(32'd9), 0, "R8");
        send_cell(2, 1'b0, 16'h0,    32'h0,         mk_payload(32'd10), 0, "R8");
        send_cell(9, 1'b0, 16'h0,    32'h0,         mk_payload(32'd11), 0, "R8");
    endtask

    task automatic t_gaps();
        send_cell(3, 1'b1, 16'h0303, 32'h0003_0000, mk_payload(32'd12), 2, "R11");
        send_cell(3, 1'b0, 16'h0,    32'h0,         mk_payload(32'd13), 3, "R11");
        t_single_pulse();
    endtask

    task automatic t_fresh_and_restart();
        send_cell(12, 1'b0, 16'hFFFF, 32'hFFFF_0000, mk_payload(32'd14), 0, "R10");
        send_cell(5,  1'b1, 16'h4321, 32'h0009_0000, mk_payload(32'd15), 0, "R3");
        send_cell(4,  1'b1, 16'h0044, 32'h0004_0000, mk_payload(32'd16), 1, "R7");
    endtask

    initial begin
        t_reset();
        t_first_and_continue();
        t_timer_and_isolation();
        t_back_to_back();
        t_gaps();
        t_fresh_and_restart();
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule